// File: doc/BRIEF.md
# Configuration Space Window Decoder

This block keeps a 64-bit programmable register that places a memory-mapped window for PCI Express configuration accesses inside a 39-bit memory address space. It checks each incoming memory address against the window. When the address falls inside an enabled window, the block raises a hit and breaks the address into a bus number, a device number, a function number and a byte offset, ready for translation into a configuration cycle. Each function owns a 4 KB slice of the window. The slice for a function begins at the window base plus bus × 1 MB plus device × 32 KB plus function × 4 KB.

Software programs the register through a 64-bit write port with one enable per byte. It reads the register back on a read-data output that is always valid. The window can be 256 MB, 128 MB or 64 MB. The size decides how many address bits are compared, and whether register bits 27 and 26 hold base bits or read as zero. A lock input freezes every writable field. The hit and field outputs are combinational from the address and the current register contents.

Top module: `cfgwin_decoder`

## Requirements
- R1: After a synchronous active-low reset, the register reads 0 and no address hits.
- R2: Register bits 63:39 and 25:3 always read 0, whatever data is written to them.
- R3: Bits 38:28 hold the window base. Bits 2:1 hold the size code. Bit 0 is the enable. A write to these bits reads back unchanged.
- R4: Bit 27 keeps written data only while the size code is 01 or 10. Bit 26 keeps written data only while the code is 10. Under any other code, each of these bits reads 0. A bit that is cleared by a size change stays 0 when the size code changes again.
- R5: With the enable set, size code 00 compares address bits 38:28 with the base. Code 01 compares bits 38:27, and code 10 compares bits 38:26. A match raises the hit.
- R6: With the enable clear, no address hits, and the base bits can still be written and read back.
- R7: Size code 11 is reserved. Under this code no address hits, even with the enable set.
- R8: On a hit, the outputs are as follows: device is address bits 19:15, function is bits 14:12, and offset is bits 11:0. Bus is bits 27:20 under code 00, bits 26:20 under code 01, and bits 25:20 under code 10, with the upper bits zero. With no hit, all four field outputs are 0.
- R9: Byte enable k controls register bits 8k+7 down to 8k. A bit whose byte enable is clear keeps its value.
- R10: While the lock input is high, a write leaves the register contents, and therefore the decode, unchanged.
- R11: The hit follows an address change in the same cycle. A register write changes the decode only after the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_i | input | 1 | Freezes all writable register fields while high |
| reg_we_i | input | 1 | Register write strobe |
| reg_be_i | input | 8 | Byte enables for the write |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Current register contents |
| chk_addr_i | input | 39 | Memory address to check |
| chk_hit_o | output | 1 | Address falls inside the enabled window |
| chk_bus_o | output | 8 | Decoded bus number |
| chk_dev_o | output | 5 | Decoded device number |
| chk_fn_o | output | 3 | Decoded function number |
| chk_off_o | output | 12 | Decoded byte offset |

## Verification
The bench targets four boundaries, each tied to a specific design mistake:
- **Highest bus at each size.** If a design did not mask the bus by size, 128 MB and 64 MB windows would report 255 instead of 127 or 63.
- **Flipped bit 27 or bit 26.** Under the smaller sizes, an address with one of these bits flipped must miss. A design that compared too few bits would claim it.
- **Shrink to 256 MB, then grow back.** A design that only masked these bits on read would let stale base bits come back when the window grows.
- **Reserved code, lock and single-byte writes.** The reserved size code, the lock, and partial-byte writes are each exercised. The timing of a new write is also checked: a design that let write data straight through to the decoder would show the new hit before the clock edge.

// File: rtl/cfgwin_pkg.sv
// Package: shared types and helpers for the configuration window decoder.
// Assumes the size code is two bits wide, with 11 reserved.
package cfgwin_pkg;

    typedef enum logic [1:0] {
        SZ_FULL    = 2'b00,
        SZ_HALF    = 2'b01,
        SZ_QUARTER = 2'b10,
        SZ_RSVD    = 2'b11
    } win_size_e;

    // Number of base bits below the fixed base field that the given size compares
    function automatic int opt_count(win_size_e s);
        return (s == SZ_RSVD) ? 0 : int'(s);
    endfunction

endpackage

// File: rtl/cfgwin_reg.sv
// Module: cfgwin_reg
// Holds the window register: base, optional low base bits, size and enable.
// Per-byte write enables; reserved bits are not stored and read as zero.
// An optional base bit is kept only while the written size compares it.
// Assumes DATA_W is a multiple of 8, ADDR_W <= DATA_W, and that the
// size and enable share byte 0.
module cfgwin_reg
    import cfgwin_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int ADDR_W   = 39,
    parameter int BASE_LSB = 28,
    parameter int N_OPT    = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         lock_i,
    input  logic                         we_i,
    input  logic [DATA_W/8-1:0]          be_i,
    input  logic [DATA_W-1:0]            wdata_i,
    output logic [DATA_W-1:0]            rdata_o,
    output logic [ADDR_W-BASE_LSB-1:0]   base_hi_o,
    output logic [N_OPT-1:0]             base_opt_o,
    output win_size_e                    size_o,
    output logic                         en_o
);

    localparam int HI_W   = ADDR_W - BASE_LSB;
    localparam int RSV_LO = BASE_LSB - N_OPT - 1;

    logic [HI_W-1:0]  hi_q,  hi_n;
    logic [N_OPT-1:0] opt_q, opt_n;
    win_size_e        size_q, size_n;
    logic             en_q,  en_n;
    logic             unused_wdata;

    // Reserved write-data bits have no storage behind them
    assign unused_wdata = ^{wdata_i[DATA_W-1:ADDR_W], wdata_i[RSV_LO:3]};

    // Merge write data into each field under its byte enables
    always_comb begin
        size_n = be_i[0] ? win_size_e'(wdata_i[2:1]) : size_q;
        en_n   = be_i[0] ? wdata_i[0] : en_q;
        for (int i = 0; i < HI_W; i++) begin
            hi_n[i] = be_i[(BASE_LSB + i) / 8] ? wdata_i[BASE_LSB + i] : hi_q[i];
        end
        for (int k = 0; k < N_OPT; k++) begin
            opt_n[k] = be_i[(BASE_LSB - 1 - k) / 8] ? wdata_i[BASE_LSB - 1 - k] : opt_q[k];
            if (k >= opt_count(size_n)) begin
                opt_n[k] = 1'b0;
            end
        end
    end

    // Register update: reset to zero, take unlocked writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            opt_q  <= '0;
            size_q <= SZ_FULL;
            en_q   <= 1'b0;
        end else if (we_i && !lock_i) begin
            hi_q   <= hi_n;
            opt_q  <= opt_n;
            size_q <= size_n;
            en_q   <= en_n;
        end
    end

    // Read-back image with reserved bits forced to zero
    always_comb begin
        rdata_o = '0;
        rdata_o[ADDR_W-1:BASE_LSB] = hi_q;
        for (int k = 0; k < N_OPT; k++) begin
            rdata_o[BASE_LSB - 1 - k] = opt_q[k];
        end
        rdata_o[2:1] = size_q;
        rdata_o[0]   = en_q;
    end

    assign base_hi_o  = hi_q;
    assign base_opt_o = opt_q;
    assign size_o     = size_q;
    assign en_o       = en_q;

    // R10: a locked cycle leaves the register image unchanged
    assert_lock_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> $stable(rdata_o));

    // R4: optional base bits beyond the current size read as zero
    assert_opt_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (base_opt_o >> opt_count(size_o)) == '0);

endmodule

// File: rtl/cfgwin_match.sv
// Module: cfgwin_match
// Compares an address with the window register and splits a hit into
// bus, device, function and offset. Purely combinational; the clock and
// reset only time the assertions. Assumes offset, function and device
// occupy address bits 19:0 and the bus sits between bit 20 and BASE_LSB.
module cfgwin_match
    import cfgwin_pkg::*;
#(
    parameter int ADDR_W   = 39,
    parameter int BASE_LSB = 28,
    parameter int N_OPT    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [ADDR_W-BASE_LSB-1:0]  base_hi_i,
    input  logic [N_OPT-1:0]            base_opt_i,
    input  win_size_e                   size_i,
    input  logic                        en_i,
    output logic                        hit_o,
    output logic [BASE_LSB-21:0]        bus_o,
    output logic [4:0]                  dev_o,
    output logic [2:0]                  fn_o,
    output logic [11:0]                 off_o
);

    localparam int BUS_W = BASE_LSB - 20;

    logic [N_OPT-1:0] opt_ok;
    logic             hi_ok;
    logic [BUS_W-1:0] bus_mask;

    // One comparator per optional base bit, used only when the size asks for it
    for (genvar k = 0; k < N_OPT; k++) begin : g_opt
        assign opt_ok[k] = (k >= opt_count(size_i)) ||
                           (addr_i[BASE_LSB - 1 - k] == base_opt_i[k]);
    end

    // Fixed base comparison and overall window claim
    always_comb begin
        hi_ok = (addr_i[ADDR_W-1:BASE_LSB] == base_hi_i);
        hit_o = en_i && (size_i != SZ_RSVD) && hi_ok && (&opt_ok);
    end

    // Field split, bus narrowed to the window size, zero on a miss
    always_comb begin
        bus_mask = {BUS_W{1'b1}} >> opt_count(size_i);
        bus_o = '0;
        dev_o = '0;
        fn_o  = '0;
        off_o = '0;
        if (hit_o) begin
            bus_o = addr_i[BASE_LSB-1:20] & bus_mask;
            dev_o = addr_i[19:15];
            fn_o  = addr_i[14:12];
            off_o = addr_i[11:0];
        end
    end

    // R6: a disabled window never claims an address
    assert_off_no_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !hit_o);

    // R7: the reserved size never claims an address
    assert_rsvd_no_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == SZ_RSVD) |-> !hit_o);

    // R8: fields stay zero when nothing is claimed
    assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (bus_o == '0 && dev_o == '0 && fn_o == '0 && off_o == '0));

    // R8: the smallest window never reports a bus beyond its range
    assert_bus_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == SZ_QUARTER) |-> (bus_o[BUS_W-1 -: 2] == 2'b00));

endmodule

// File: rtl/cfgwin_decoder.sv
// Module: cfgwin_decoder (top)
// Window register plus address decoder for memory-mapped configuration
// accesses. Register writes apply at the clock edge; decode is
// combinational from the address and the stored register.
module cfgwin_decoder
    import cfgwin_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int ADDR_W   = 39,
    parameter int BASE_LSB = 28,
    parameter int N_OPT    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lock_i,
    input  logic                  reg_we_i,
    input  logic [DATA_W/8-1:0]   reg_be_i,
    input  logic [DATA_W-1:0]     reg_wdata_i,
    output logic [DATA_W-1:0]     reg_rdata_o,
    input  logic [ADDR_W-1:0]     chk_addr_i,
    output logic                  chk_hit_o,
    output logic [BASE_LSB-21:0]  chk_bus_o,
    output logic [4:0]            chk_dev_o,
    output logic [2:0]            chk_fn_o,
    output logic [11:0]           chk_off_o
);

    localparam int HI_W = ADDR_W - BASE_LSB;

    logic [HI_W-1:0]  base_hi;
    logic [N_OPT-1:0] base_opt;
    win_size_e        size;
    logic             en;

    cfgwin_reg #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB), .N_OPT(N_OPT)
    ) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_i     (lock_i),
        .we_i       (reg_we_i),
        .be_i       (reg_be_i),
        .wdata_i    (reg_wdata_i),
        .rdata_o    (reg_rdata_o),
        .base_hi_o  (base_hi),
        .base_opt_o (base_opt),
        .size_o     (size),
        .en_o       (en)
    );

    cfgwin_match #(
        .ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB), .N_OPT(N_OPT)
    ) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (chk_addr_i),
        .base_hi_i  (base_hi),
        .base_opt_i (base_opt),
        .size_i     (size),
        .en_i       (en),
        .hit_o      (chk_hit_o),
        .bus_o      (chk_bus_o),
        .dev_o      (chk_dev_o),
        .fn_o       (chk_fn_o),
        .off_o      (chk_off_o)
    );

    // R5: a claimed address carries the stored fixed base bits
    assert_hit_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
        chk_hit_o |-> (chk_addr_i[ADDR_W-1:BASE_LSB] == reg_rdata_o[ADDR_W-1:BASE_LSB]));

endmodule

// File: tb/tb_cfgwin_decoder.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_cfgwin_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock_i = 1'b0;
    logic        reg_we_i = 1'b0;
    logic [7:0]  reg_be_i = '0;
    logic [63:0] reg_wdata_i = '0;
    logic [63:0] reg_rdata_o;
    logic [38:0] chk_addr_i = '0;
    logic        chk_hit_o;
    logic [7:0]  chk_bus_o;
    logic [4:0]  chk_dev_o;
    logic [2:0]  chk_fn_o;
    logic [11:0] chk_off_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    cfgwin_decoder dut (
        .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .reg_we_i(reg_we_i),
        .reg_be_i(reg_be_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .chk_addr_i(chk_addr_i), .chk_hit_o(chk_hit_o), .chk_bus_o(chk_bus_o),
        .chk_dev_o(chk_dev_o), .chk_fn_o(chk_fn_o), .chk_off_o(chk_off_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] be, input logic [63:0] data, input logic lk);
        @(negedge clk);
        reg_we_i = 1'b1; reg_be_i = be; reg_wdata_i = data; lock_i = lk;
        @(negedge clk);
        reg_we_i = 1'b0; reg_be_i = '0; lock_i = 1'b0;
        #1;
    endtask

    // Drive an address and compare {hit, bus, dev, fn, off}
    task automatic probe(input string req, input logic [38:0] a, input logic h,
                         input logic [7:0] b, input logic [4:0] d,
                         input logic [2:0] f, input logic [11:0] o);
        chk_addr_i = a;
        #1;
        check(req, {35'd0, chk_hit_o, chk_bus_o, chk_dev_o, chk_fn_o, chk_off_o},
                   {35'd0, h, b, d, f, o});
    endtask

    task automatic t_reset;
        check("R1 reset value", reg_rdata_o, 64'h0);
        probe("R1 no hit after reset", 39'h0, 1'b0, 8'd0, 5'd0, 3'd0, 12'd0);
    endtask

    task automatic t_full;
        wr(8'hFF, 64'hFFFF_FF80_EFFF_FFF9, 1'b0);
        check("R2 R3 R4 full-size readback", reg_rdata_o, 64'h0000_0000_E000_0001);
        probe("R5 R8 hit 256MB", 39'h0E051A1A4, 1'b1, 8'd5, 5'd3, 3'd2, 12'h1A4);
        probe("R8 top bus 256MB", 39'h0EFF00000, 1'b1, 8'd255, 5'd0, 3'd0, 12'h0);
        probe("R5 R8 miss 256MB", 39'h0F0000000, 1'b0, 8'd0, 5'd0, 3'd0, 12'h0);
        probe("R5 miss high bit", 39'h4E0000000, 1'b0, 8'd0, 5'd0, 3'd0, 12'h0);
    endtask

    task automatic t_half;
        wr(8'hFF, 64'h0000_0000_EC00_0003, 1'b0);
        check("R4 128MB keeps bit27 only", reg_rdata_o, 64'h0000_0000_E800_0003);
        probe("R8 top bus 128MB", 39'h0EFF00000, 1'b1, 8'd127, 5'd0, 3'd0, 12'h0);
        probe("R5 bit27 flip misses", 39'h0E7F00000, 1'b0, 8'd0, 5'd0, 3'd0, 12'h0);
    endtask

    task automatic t_quarter;
        wr(8'hFF, 64'h0000_0000_EC00_0005, 1'b0);
        check("R4 64MB keeps bits 27:26", reg_rdata_o, 64'h0000_0000_EC00_0005);
        probe("R8 top bus 64MB", 39'h0EFF00000, 1'b1, 8'd63, 5'd0, 3'd0, 12'h0);
        probe("R5 bit26 flip misses", 39'h0E8000000, 1'b0, 8'd0, 5'd0, 3'd0, 12'h0);
    endtask

    task automatic t_shrink;
        wr(8'h01, 64'h1, 1'b0);
        check("R4 shrink clears bits 27:26", reg_rdata_o, 64'h0000_0000_E000_0001);
        wr(8'h01, 64'h3, 1'b0);
        check("R4 cleared bit stays 0 on regrow", reg_rdata_o, 64'h0000_0000_E000_0003);
        probe("R5 128MB with bit27 0", 39'h0E0000000, 1'b1, 8'd0, 5'd0, 3'd0, 12'h0);
    endtask

    task automatic t_bytes;
        wr(8'h10, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        check("R9 single byte lane", reg_rdata_o, 64'h0000_007F_E000_0003);
        wr(8'hFF, 64'h0000_0000_E000_0003, 1'b0);
        check("R9 full restore", reg_rdata_o, 64'h0000_0000_E000_0003);
    endtask

    task automatic t_disabled;
        wr(8'hFF, 64'h0000_0000_2000_0000, 1'b0);
        check("R6 base writable while off", reg_rdata_o, 64'h0000_0000_2000_0000);
        probe("R6 no hit while off", 39'h020000000, 1'b0, 8'd0, 5'd0, 3'd0, 12'h0);
    endtask

    task automatic t_rsvd;
        wr(8'hFF, 64'h0000_0000_2C00_0007, 1'b0);
        check("R7 R4 reserved size readback", reg_rdata_o, 64'h0000_0000_2000_0007);
        probe("R7 reserved size no hit", 39'h020000000, 1'b0, 8'd0, 5'd0, 3'd0, 12'h0);
    endtask

    task automatic t_lock;
        wr(8'hFF, 64'h0000_0000_3000_0001, 1'b0);
        wr(8'hFF, 64'h0000_0000_4000_0004, 1'b1);
        check("R10 locked write ignored", reg_rdata_o, 64'h0000_0000_3000_0001);
        probe("R10 decode unchanged", 39'h030123456, 1'b1, 8'd1, 5'd4, 3'd3, 12'h456);
        probe("R10 new base not claimed", 39'h040000000, 1'b0, 8'd0, 5'd0, 3'd0, 12'h0);
    endtask

    task automatic t_timing;
        chk_addr_i = 39'h050000000;
        @(negedge clk);
        reg_we_i = 1'b1; reg_be_i = 8'hFF; reg_wdata_i = 64'h0000_0000_5000_0001;
        #1;
        check("R11 no hit before edge", {63'd0, chk_hit_o}, 64'd0);
        @(posedge clk);
        #1;
        reg_we_i = 1'b0; reg_be_i = '0;
        check("R11 hit after edge", {63'd0, chk_hit_o}, 64'd1);
        probe("R11 address change same cycle", 39'h050100000, 1'b1, 8'd1, 5'd0, 3'd0, 12'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_full();
        t_half();
        t_quarter();
        t_shrink();
        t_bytes();
        t_disabled();
        t_rsvd();
        t_lock();
        t_timing();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule